// File: doc/BRIEF.md
# Indexed Block Configuration Register Slave for a Two-Wire Management Bus

This block is a slave on an SMBus-style two-wire bus. It gives a host access to a small bank of 8-bit configuration registers. The host moves runs of consecutive registers in one transaction, beginning at any index it chooses. The block samples SCL and SDA with a fast system clock and passes both lines through a synchronizer and a glitch filter. From the filtered lines it detects start, repeated start and stop conditions. It drives SDA only through an open-drain enable, pulling the line low when needed.

In a write, the host sends the write address, then a starting index, then how many bytes follow, then the bytes themselves. In a read, the host first sets the index with a short write, then issues a repeated start and the read address. The slave answers with a count byte, taken from a 6-bit field of one of its own registers, and then streams register contents until the host stops acknowledging.

Each register has a per-bit write mask and a reset value, both set by parameters. Bits outside the mask never change. On a read, each such bit returns the matching bit of an input vector, so latched strap and frequency-select values can be read back.

Top module: `smb_regbank_slave`

## Requirements
- R1: After a synchronous active-low reset, sda_oe is 0, cfg_o equals RST_VAL, and a read returns the reset contents.
- R2: The slave acknowledges only address byte {DEV_ADDR7,0} (D2h by default) for writes and {DEV_ADDR7,1} (D3h) for reads. For any other address byte it does not acknowledge, and it leaves SDA released and the registers unchanged until the next start or stop.
- R3: In a write, the first byte after the address is the start index N and the second is a count X. The next X data bytes are each acknowledged and stored into registers N, N+1, and onward, one after another.
- R4: Only bits set in the register's RW_MASK byte (bit i of the byte masks register bit i) take written data. In cfg_o, masked-out bits keep their reset value. On a read, a masked-out bit returns bit k*8+i of ro_i for register k.
- R5: The index advances by one after every data byte, wrapping at 8 bits. A data byte aimed at an index at or above NREG is acknowledged and discarded. A read at such an index returns 00h.
- R6: A write data byte that arrives after the X counted bytes is not acknowledged and is not stored.
- R7: After the read address, the slave first sends a count byte, which is bits [CNT_W-1:0] of register BC_IDX zero-extended (reset field 0Dh). It then sends register N, N+1 and onward, MSB first. While SCL is high, the slave changes sda_oe only in response to a start or a stop.
- R8: After the host leaves a read byte unacknowledged, the slave keeps SDA released on every further SCL pulse until the next start or stop.
- R9: A stop or start condition that arrives partway through a byte abandons that byte without storing it. Bytes already acknowledged stay stored. A new address after a mid-byte start is decoded normally.
- R10: SCL pulses shorter than FILT system clock cycles are ignored, and the transfer continues as if no pulse had occurred.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16 times the SCL rate |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| ro_i | input | NREG*8 | Values returned by bits that are not writable |
| cfg_o | output | NREG*8 | Stored register contents, register k at bits k*8+7:k*8 |

## Verification
The bench builds the block with six registers, the count register at index 5, and masks chosen so that the bank contains a fully writable register, a fully read-only one, two half-masked ones and the count register. With only six registers, the bench can cover every start index from 0 to 7 with every count from 0 to 2. That sweep includes writes that run past the last register and writes into the count register itself, so the very next read shows the new count byte. Each write ends with one surplus byte, which should be refused, and each write is followed by a full read-back. Separate transactions cover a foreign address, abandoned bytes, a glitched SCL and the released bus after a read NACK.

// File: rtl/smb_pkg.sv
// Shared definitions for the indexed register slave.
// Assumes: byte-wide registers and an 8-bit index space.
package smb_pkg;

    localparam int BYTE_W = 8;

    // Protocol phase of the link engine.
    typedef enum logic [2:0] {
        LK_IDLE,   // bus free or not addressed
        LK_ADDR,   // shifting in the address byte
        LK_INDEX,  // shifting in the start index
        LK_COUNT,  // shifting in the write byte count
        LK_WDATA,  // shifting in write data
        LK_TX,     // sending count and data to the host
        LK_SKIP    // ignoring the bus until start or stop
    } link_state_t;

endpackage

// File: rtl/smb_pin_filter.sv
// Two-flop synchronizer followed by a persistence filter for one bus line.
// Output follows the input only after it has disagreed for FILT cycles.
// Assumes: idle bus level is high, FILT >= 1.
module smb_pin_filter #(
    parameter int FILT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic pin_o
);
    localparam int CW = $clog2(FILT + 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // Bring the asynchronous pad level into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], pin_i};
    end

    // Accept a new level only after FILT consecutive disagreeing samples.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin_o <= 1'b1;
            run_q <= '0;
        end else if (sync_q[1] == pin_o) begin
            run_q <= '0;
        end else if (run_q == CW'(FILT - 1)) begin
            pin_o <= sync_q[1];
            run_q <= '0;
        end else begin
            run_q <= run_q + CW'(1);
        end
    end
endmodule

// File: rtl/smb_bus_events.sv
// Turns filtered SCL/SDA levels into single-cycle bus events.
// Assumes: inputs are already synchronous and free of short glitches.
module smb_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_d, sda_d;

    // Remember last cycle's line levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    // SDA edges with SCL held high mark start/stop; SCL edges mark bits.
    always_comb begin
        start_ev = scl_d && scl_f && sda_d && !sda_f;
        stop_ev  = scl_d && scl_f && !sda_d && sda_f;
        scl_rise = !scl_d && scl_f;
        scl_fall = scl_d && !scl_f;
    end
endmodule

// File: rtl/smb_cfg_regfile.sv
// Bank of byte registers with per-bit write masks and reset values.
// Masked-out bits keep their reset value and read back from ro_i.
// Assumes: BC_IDX < NREG and CNT_W <= 8.
module smb_cfg_regfile #(
    parameter int               NREG    = 13,
    parameter int               BC_IDX  = 12,
    parameter int               CNT_W   = 6,
    parameter logic [NREG*8-1:0] RW_MASK = '1,
    parameter logic [NREG*8-1:0] RST_VAL = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [7:0]        waddr,
    input  logic [7:0]        wdata,
    input  logic [7:0]        rd_idx,
    input  logic [NREG*8-1:0] ro_i,
    output logic [7:0]        rd_data,
    output logic [7:0]        cnt_byte,
    output logic [NREG*8-1:0] cfg_o
);
    logic [7:0] view [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        localparam logic [7:0] MSK = RW_MASK[g*8 +: 8];
        localparam logic [7:0] RST = RST_VAL[g*8 +: 8];
        logic [7:0] q;

        // Store writable bits of a byte addressed to this register.
        always_ff @(posedge clk) begin
            if (!rst_n)                       q <= RST;
            else if (we && waddr == 8'(g))    q <= (wdata & MSK) | (q & ~MSK);
        end

        assign cfg_o[g*8 +: 8] = q;
        assign view[g]         = (q & MSK) | (ro_i[g*8 +: 8] & ~MSK);
    end

    // Select the host-visible byte; indices past the bank read as zero.
    always_comb begin
        rd_data = 8'h00;
        for (int k = 0; k < NREG; k++) begin
            if (rd_idx == 8'(k)) rd_data = view[k];
        end
    end

    // Count byte sent ahead of read data.
    assign cnt_byte = 8'(cfg_o[BC_IDX*8 +: CNT_W]);
endmodule

// File: rtl/smb_link_fsm.sv
// Byte-level protocol engine: address match, index/count capture,
// counted writes with auto-increment, and count-prefixed reads.
// Assumes: events come from smb_bus_events; no clock stretching.
module smb_link_fsm
    import smb_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR7 = 7'h69
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_f,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic [7:0] rd_data,
    input  logic [7:0] cnt_byte,
    output logic       sda_oe,
    output logic       we,
    output logic [7:0] waddr,
    output logic [7:0] wdata,
    output logic [7:0] ptr,
    output logic       idle
);
    link_state_t state, nxt;
    logic [3:0]  bitcnt;
    logic [7:0]  shreg, txbyte, left;
    logic        in_ack, host_ack, rx_st;
    logic [2:0]  bit_sel;

    assign rx_st   = (state == LK_ADDR) || (state == LK_INDEX) ||
                     (state == LK_COUNT) || (state == LK_WDATA);
    assign bit_sel = 3'(4'd7 - bitcnt);
    assign idle    = (state == LK_IDLE);

    // Sequence bits, acknowledges and byte actions on bus events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= LK_IDLE;
            nxt      <= LK_IDLE;
            bitcnt   <= '0;
            shreg    <= '0;
            txbyte   <= '0;
            left     <= '0;
            ptr      <= '0;
            in_ack   <= 1'b0;
            host_ack <= 1'b0;
            sda_oe   <= 1'b0;
            we       <= 1'b0;
            waddr    <= '0;
            wdata    <= '0;
        end else begin
            we <= 1'b0;
            if (stop_ev) begin
                state  <= LK_IDLE;
                sda_oe <= 1'b0;
                in_ack <= 1'b0;
                bitcnt <= '0;
            end else if (start_ev) begin
                state  <= LK_ADDR;
                sda_oe <= 1'b0;
                in_ack <= 1'b0;
                bitcnt <= '0;
            end else if (scl_rise) begin
                if (rx_st && !in_ack && bitcnt < 4'd8) begin
                    shreg  <= {shreg[6:0], sda_f};
                    bitcnt <= bitcnt + 4'd1;
                end else if (state == LK_TX && !in_ack && bitcnt < 4'd8) begin
                    bitcnt <= bitcnt + 4'd1;
                end else if (state == LK_TX && in_ack) begin
                    host_ack <= !sda_f;
                end
            end else if (scl_fall) begin
                if (rx_st && !in_ack && bitcnt == 4'd8) begin
                    unique case (state)
                        LK_ADDR: begin
                            if (shreg == {DEV_ADDR7, 1'b0}) begin
                                in_ack <= 1'b1; sda_oe <= 1'b1; nxt <= LK_INDEX;
                            end else if (shreg == {DEV_ADDR7, 1'b1}) begin
                                in_ack <= 1'b1; sda_oe <= 1'b1; nxt <= LK_TX;
                            end else begin
                                state <= LK_SKIP;
                            end
                        end
                        LK_INDEX: begin
                            ptr <= shreg; in_ack <= 1'b1; sda_oe <= 1'b1; nxt <= LK_COUNT;
                        end
                        LK_COUNT: begin
                            left <= shreg; in_ack <= 1'b1; sda_oe <= 1'b1; nxt <= LK_WDATA;
                        end
                        default: begin
                            if (left != 8'd0) begin
                                we     <= 1'b1;
                                waddr  <= ptr;
                                wdata  <= shreg;
                                ptr    <= ptr + 8'd1;
                                left   <= left - 8'd1;
                                in_ack <= 1'b1;
                                sda_oe <= 1'b1;
                                nxt    <= LK_WDATA;
                            end else begin
                                state <= LK_SKIP;
                            end
                        end
                    endcase
                end else if (rx_st && in_ack) begin
                    in_ack <= 1'b0;
                    bitcnt <= '0;
                    state  <= nxt;
                    if (nxt == LK_TX) begin
                        txbyte <= cnt_byte;
                        sda_oe <= !cnt_byte[7];
                    end else begin
                        sda_oe <= 1'b0;
                    end
                end else if (state == LK_TX && !in_ack && bitcnt != 4'd0 && bitcnt < 4'd8) begin
                    sda_oe <= !txbyte[bit_sel];
                end else if (state == LK_TX && !in_ack && bitcnt == 4'd8) begin
                    sda_oe <= 1'b0;
                    in_ack <= 1'b1;
                end else if (state == LK_TX && in_ack) begin
                    in_ack <= 1'b0;
                    if (host_ack) begin
                        txbyte <= rd_data;
                        sda_oe <= !rd_data[7];
                        ptr    <= ptr + 8'd1;
                        bitcnt <= '0;
                    end else begin
                        state  <= LK_SKIP;
                        sda_oe <= 1'b0;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/smb_regbank_slave.sv
// Top level: line filters, event detector, link engine and register bank.
// Assumes: clk runs at least 16x the SCL rate; SDA is open-drain with
// an external pull-up, so sda_oe=1 means drive low.
module smb_regbank_slave #(
    parameter int                NREG      = 13,
    parameter int                BC_IDX    = 12,
    parameter int                CNT_W     = 6,
    parameter int                FILT      = 3,
    parameter logic [6:0]        DEV_ADDR7 = 7'h69,
    parameter logic [NREG*8-1:0] RW_MASK   = {8'h3F, {(NREG-2){8'hFF}}, 8'h1F},
    parameter logic [NREG*8-1:0] RST_VAL   = {8'h0D, {(NREG-2){8'hFF}}, 8'h00}
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [NREG*8-1:0] ro_i,
    output logic [NREG*8-1:0] cfg_o
);
    localparam int NLINE = 2;

    logic [NLINE-1:0] raw_lines, filt_lines;
    logic scl_filt, sda_filt;
    logic start_ev, stop_ev, scl_rise, scl_fall;
    logic reg_we, link_idle;
    logic [7:0] reg_waddr, reg_wdata, rd_idx, rd_data, cnt_byte;

    assign raw_lines = {sda_i, scl_i};

    for (genvar l = 0; l < NLINE; l++) begin : g_line
        smb_pin_filter #(.FILT(FILT)) u_filt (
            .clk   (clk),
            .rst_n (rst_n),
            .pin_i (raw_lines[l]),
            .pin_o (filt_lines[l])
        );
    end

    assign scl_filt = filt_lines[0];
    assign sda_filt = filt_lines[1];

    smb_bus_events u_events (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_filt),
        .sda_f    (sda_filt),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    smb_link_fsm #(.DEV_ADDR7(DEV_ADDR7)) u_link (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_f    (sda_filt),
        .start_ev (start_ev),
        .stop_ev  (stop_ev),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .rd_data  (rd_data),
        .cnt_byte (cnt_byte),
        .sda_oe   (sda_oe),
        .we       (reg_we),
        .waddr    (reg_waddr),
        .wdata    (reg_wdata),
        .ptr      (rd_idx),
        .idle     (link_idle)
    );

    smb_cfg_regfile #(
        .NREG    (NREG),
        .BC_IDX  (BC_IDX),
        .CNT_W   (CNT_W),
        .RW_MASK (RW_MASK),
        .RST_VAL (RST_VAL)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (reg_we),
        .waddr    (reg_waddr),
        .wdata    (reg_wdata),
        .rd_idx   (rd_idx),
        .ro_i     (ro_i),
        .rd_data  (rd_data),
        .cnt_byte (cnt_byte),
        .cfg_o    (cfg_o)
    );
endmodule

// File: rtl/smb_regbank_checker.sv
// Temporal checks on the register slave, bound into every instance.
// Assumes: synchronous active-low reset held for at least one clock.
module smb_regbank_checker #(
    parameter int                NREG    = 13,
    parameter logic [NREG*8-1:0] RW_MASK = '1,
    parameter logic [NREG*8-1:0] RST_VAL = '0
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sda_oe,
    input logic [NREG*8-1:0] cfg_o,
    input logic              scl_filt,
    input logic              reg_we,
    input logic [7:0]        reg_waddr,
    input logic              link_idle
);
    // R1
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!sda_oe && cfg_o == RST_VAL));

    // R2
    idle_released_chk: assert property (@(posedge clk) disable iff (!rst_n)
        link_idle |-> !sda_oe);

    // R3
    store_acked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> sda_oe);

    // R4
    ro_bits_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(cfg_o & ~RW_MASK));

    // R5
    out_of_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr >= 8'(NREG)) |=> $stable(cfg_o));

    // R7
    sda_moves_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_filt);
endmodule

bind smb_regbank_slave smb_regbank_checker #(
    .NREG    (NREG),
    .RW_MASK (RW_MASK),
    .RST_VAL (RST_VAL)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sda_oe    (sda_oe),
    .cfg_o     (cfg_o),
    .scl_filt  (scl_filt),
    .reg_we    (reg_we),
    .reg_waddr (reg_waddr),
    .link_idle (link_idle)
);

// File: tb/smb_regbank_slave_test.sv
`timescale 1ns/1ps
// Bench: six-register bank, sweeps start index and count, models the
// bank arithmetically and compares every acknowledge and read byte.
module smb_regbank_slave_test;
    localparam int NREG = 6;
    localparam int BC   = 5;
    localparam int Q    = 8;
    localparam logic [NREG*8-1:0] RWM = {8'h3F, 8'hFF, 8'h00, 8'hF0, 8'h0F, 8'hFF};
    localparam logic [NREG*8-1:0] RSV = {8'h0D, 8'h5A, 8'hC3, 8'h81, 8'h24, 8'h00};
    localparam logic [NREG*8-1:0] ROV = {8'h96, 8'h3C, 8'hE7, 8'h18, 8'h5A, 8'hC3};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic glitch_on = 1'b0;
    logic sda_oe;
    logic sda_line;
    logic [NREG*8-1:0] cfg_o;
    int checks = 0;
    int failures = 0;
    bit done = 1'b0;
    logic [7:0] mdl [NREG];

    always #2 clk = ~clk;
    assign sda_line = !(m_low || sda_oe);

    smb_regbank_slave #(
        .NREG(NREG), .BC_IDX(BC), .CNT_W(6), .FILT(3), .DEV_ADDR7(7'h69),
        .RW_MASK(RWM), .RST_VAL(RSV)
    ) uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .ro_i(ROV), .cfg_o(cfg_o)
    );

    task automatic chk(input bit ok, input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] view(input int i);
        if (i >= NREG) return 8'h00;
        return (mdl[i] & RWM[i*8 +: 8]) | (ROV[i*8 +: 8] & ~RWM[i*8 +: 8]);
    endfunction

    task automatic model_wr(input int i, input logic [7:0] d);
        if (i < NREG) mdl[i] = (d & RWM[i*8 +: 8]) | (mdl[i] & ~RWM[i*8 +: 8]);
    endtask

    task automatic cfg_cmp(input string req);
        for (int i = 0; i < NREG; i++)
            chk(cfg_o[i*8 +: 8] == mdl[i], req, cfg_o[i*8 +: 8], mdl[i]);
    endtask

    task automatic wait_q(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(input logic b, output logic r);
        wait_q(Q);
        m_low = !b;
        if (glitch_on) begin
            wait_q(Q/2); scl = 1'b1; wait_q(1); scl = 1'b0; wait_q(Q/2 - 1);
        end else wait_q(Q);
        scl = 1'b1;
        wait_q(Q);
        r = sda_line;
        wait_q(Q);
        scl = 1'b0;
    endtask

    task automatic bus_start();
        wait_q(Q); m_low = 1'b0; wait_q(Q); scl = 1'b1;
        wait_q(Q); m_low = 1'b1; wait_q(Q); scl = 1'b0;
    endtask

    task automatic bus_stop();
        wait_q(Q); m_low = 1'b1; wait_q(Q); scl = 1'b1;
        wait_q(Q); m_low = 1'b0; wait_q(2*Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic ack);
        logic r;
        for (int i = 7; i >= 0; i--) xbit(b[i], r);
        xbit(1'b1, r);
        ack = !r;
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] v);
        logic r;
        for (int i = 7; i >= 0; i--) begin xbit(1'b1, r); v[i] = r; end
        xbit(!give_ack, r);
    endtask

    task automatic do_write(input int idx, input int cnt, input bit extra);
        logic a;
        logic [7:0] d;
        bus_start();
        wr_byte(8'hD2, a); chk(a, "R2 write address ack", {7'd0, a}, 8'h01);
        wr_byte(8'(idx), a); chk(a, "R3 index ack", {7'd0, a}, 8'h01);
        wr_byte(8'(cnt), a); chk(a, "R3 count ack", {7'd0, a}, 8'h01);
        for (int k = 0; k < cnt; k++) begin
            d = 8'((idx * 37 + k * 11 + cnt * 5) ^ 8'hA5);
            wr_byte(d, a);
            chk(a, (idx + k < NREG) ? "R3 data ack" : "R5 out-of-range data ack", {7'd0, a}, 8'h01);
            model_wr(idx + k, d);
        end
        if (extra) begin
            wr_byte(8'h77, a); chk(!a, "R6 surplus byte refused", {7'd0, a}, 8'h00);
        end
        bus_stop();
    endtask

    task automatic do_read(input int idx, input int n);
        logic a;
        logic [7:0] v;
        bus_start();
        wr_byte(8'hD2, a); chk(a, "R2 write address ack", {7'd0, a}, 8'h01);
        wr_byte(8'(idx), a); chk(a, "R3 index ack", {7'd0, a}, 8'h01);
        bus_start();
        wr_byte(8'hD3, a); chk(a, "R2 read address ack", {7'd0, a}, 8'h01);
        rd_byte(1'b1, v); chk(v == {2'b00, mdl[BC][5:0]}, "R7 count byte", v, {2'b00, mdl[BC][5:0]});
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, v);
            chk(v == view(idx + k), (idx + k < NREG) ? "R7 R4 read data" : "R5 read past bank", v, view(idx + k));
        end
        bus_stop();
    endtask

    initial begin
        logic a, r;
        logic [7:0] v;
        for (int i = 0; i < NREG; i++) mdl[i] = RSV[i*8 +: 8];
        wait_q(5);
        rst_n = 1'b1;
        wait_q(2);
        // R1 reset state at the ports
        chk(sda_oe == 1'b0, "R1 sda released", {7'd0, sda_oe}, 8'h00);
        cfg_cmp("R1 reset contents");
        do_read(0, NREG + 1);

        // R2 foreign address and ignored follow-on bytes
        bus_start();
        wr_byte(8'hA4, a); chk(!a, "R2 foreign address refused", {7'd0, a}, 8'h00);
        wr_byte(8'h00, a); chk(!a, "R2 ignored byte", {7'd0, a}, 8'h00);
        wr_byte(8'h02, a); chk(!a, "R2 ignored byte", {7'd0, a}, 8'h00);
        wr_byte(8'hFF, a); chk(!a, "R2 ignored byte", {7'd0, a}, 8'h00);
        bus_stop();
        cfg_cmp("R2 bank untouched");

        // R3 R4 R5 R6 sweep of start index and count
        for (int idx = 0; idx < 8; idx++) begin
            for (int cnt = 0; cnt < 3; cnt++) begin
                do_write(idx, cnt, 1'b1);
                cfg_cmp("R4 stored bits");
                do_read(0, NREG);
            end
        end

        // R5 R7 reads from every start index
        for (int idx = 0; idx < 8; idx++) do_read(idx, 2);

        // R9 stop partway through a byte
        bus_start();
        wr_byte(8'hD2, a); wr_byte(8'h01, a); wr_byte(8'h03, a);
        wr_byte(8'h3C, a); chk(a, "R9 first byte ack", {7'd0, a}, 8'h01);
        model_wr(1, 8'h3C);
        for (int i = 0; i < 4; i++) xbit(1'b1, r);
        bus_stop();
        cfg_cmp("R9 partial byte after stop");

        // R9 start partway through a byte, then a fresh write
        bus_start();
        wr_byte(8'hD2, a); wr_byte(8'h04, a); wr_byte(8'h02, a);
        wr_byte(8'h11, a); model_wr(4, 8'h11);
        for (int i = 0; i < 3; i++) xbit(1'b0, r);
        bus_start();
        wr_byte(8'hD2, a); chk(a, "R9 address after restart", {7'd0, a}, 8'h01);
        wr_byte(8'h00, a); wr_byte(8'h01, a);
        wr_byte(8'h42, a); model_wr(0, 8'h42);
        bus_stop();
        cfg_cmp("R9 bank after restart");

        // R10 short SCL pulses during every bit
        glitch_on = 1'b1;
        do_write(4, 2, 1'b0);
        glitch_on = 1'b0;
        cfg_cmp("R10 glitched write");
        do_read(3, 3);

        // R8 released bus after host NACK
        bus_start();
        wr_byte(8'hD2, a); wr_byte(8'h00, a);
        bus_start();
        wr_byte(8'hD3, a);
        rd_byte(1'b1, v);
        rd_byte(1'b0, v); chk(v == view(0), "R8 last byte", v, view(0));
        for (int i = 0; i < 9; i++) begin
            xbit(1'b1, r);
            chk(r == 1'b1, "R8 sda released after nack", {7'd0, r}, 8'h01);
        end
        bus_stop();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_q(190000);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule